// File: doc/BRIEF.md
# Memory-Mapped Serial Byte Transmitter

This block is a send-only asynchronous serial port that sits on an 8-bit processor bus with 16-bit addresses. Software stores a byte to the data address at the very top of the address space. The port then shifts that byte out on a single line as one frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit is held for `BIT_CLKS` clock cycles.

The port has no queue, so back-pressure is handled by polling. A status word one address below the data address reads 1 while a frame is on the line and 0 otherwise. Software spins on that word until it is not 1, and only then stores the next byte. A store that arrives while a frame is still going out is dropped. It neither corrupts nor delays the frame in progress.

Bus timing follows a single-cycle strobe protocol. A write presents the address and data together with a one-cycle write strobe, and the port captures the data on that edge when the address matches. A read presents the address with a one-cycle read strobe, and the port drives the answer for exactly one cycle, beginning in the next cycle.

Top module: `mmio_serial_tx`

## Requirements
- R1: While reset is asserted and after it is released, the serial line is high, the read data bus is 0 and a status read returns 0.
- R2: A write strobe with address `TX_ADDR` (default 0xFFFF) while idle captures `bus_wdata`. From the cycle after that clock edge, the line is driven low for one bit period as the start bit.
- R3: After the start bit, the eight captured data bits follow, least significant bit first, one bit per bit period.
- R4: After the eighth data bit, the line is high for one stop-bit period and then stays high while idle.
- R5: A read strobe with address `STAT_ADDR` (default 0xFFFE) returns 0x01 if a frame was in progress at the strobe edge and 0x00 otherwise. Bits 7..1 are always 0.
- R6: Every bit lasts exactly `BIT_CLKS` cycles, so a frame occupies 10×`BIT_CLKS` cycles. The earliest next write that is accepted is one sampled one cycle after the stop bit ends.
- R7: A write to `TX_ADDR` during a frame is ignored. The frame in progress is sent unchanged and no extra frame follows.
- R8: A write strobe to any address other than `TX_ADDR` starts no frame, and the line stays high.
- R9: Read data is nonzero for at most one cycle, directly after a status read strobe. At all other times, including after reads of other addresses, the read data bus is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| tx_line | output | 1 | Serial output, high when idle |

## Verification
Most state errors become visible on `tx_line` within one bit period: a wrong bit index, a wrong captured byte or a wrong state shows up as a wrong level inside the frame. A bit counter that is off by one shifts every later edge by one cycle, and by the stop bit the line is out of place by several cycles. A busy flag that clears too early lets an ignored write restart the frame, which corrupts the bits still to be sent. A stuck busy flag appears as a status read of 1 once the line has gone idle. The bench therefore compares the line against a computed frame on every cycle and polls the status word both during and after each frame.

// File: rtl/txu_pkg.sv
package txu_pkg;
  typedef enum logic [1:0] {
    TXU_IDLE  = 2'd0,
    TXU_START = 2'd1,
    TXU_DATA  = 2'd2,
    TXU_STOP  = 2'd3
  } txu_state_e;

  localparam int unsigned TXU_DEF_ADDR_W = 16;
  localparam int unsigned TXU_DEF_DATA_W = 8;
endpackage

// File: rtl/txu_bus_port.sv
module txu_bus_port #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] TX_ADDR   = '1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '1 - 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              busy,
  output logic              load,
  output logic [DATA_W-1:0] rdata
);
  logic stat_hit;

  assign load     = wr && (addr == TX_ADDR);
  assign stat_hit = rd && (addr == STAT_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (stat_hit) begin
      rdata <= {{(DATA_W-1){1'b0}}, busy};
    end else begin
      rdata <= '0;
    end
  end

  p_rdata_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != '0) |-> $past(stat_hit));
  p_status_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:1] == '0);
endmodule

// File: rtl/txu_bit_timer.sv
module txu_bit_timer #(
  parameter int unsigned BIT_CLKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CLKS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);

  p_cnt_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  generate
    if (BIT_CLKS > 1) begin : g_multi
      p_tick_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/txu_frame_fsm.sv
module txu_frame_fsm
  import txu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic              accept,
  output logic              busy,
  output logic              tx_line
);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  txu_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] hold;

  assign busy   = (state != TXU_IDLE);
  assign accept = load && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TXU_IDLE;
      idx   <= '0;
      hold  <= '0;
    end else begin
      unique case (state)
        TXU_IDLE: if (accept) begin
          state <= TXU_START;
          hold  <= wdata;
          idx   <= '0;
        end
        TXU_START: if (tick) begin
          state <= TXU_DATA;
          idx   <= '0;
        end
        TXU_DATA: if (tick) begin
          if (idx == LAST_IDX) state <= TXU_STOP;
          else                 idx   <= idx + 1'b1;
        end
        TXU_STOP: if (tick) state <= TXU_IDLE;
        default: state <= TXU_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      TXU_START: tx_line = 1'b0;
      TXU_DATA:  tx_line = hold[idx];
      default:   tx_line = 1'b1;
    endcase
  end

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_line);
  p_busy_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy) |=> $stable(hold));
  p_stop_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TXU_DATA && tick && idx == LAST_IDX) |=> (state == TXU_STOP && tx_line));
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TXU_STOP && tick) |=> tx_line);
endmodule

// File: rtl/mmio_serial_tx.sv
module mmio_serial_tx #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] TX_ADDR   = 16'hFFFF,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFFFE,
  parameter int unsigned BIT_CLKS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_line
);
  logic load, accept, busy, tick;

  txu_bus_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TX_ADDR(TX_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .busy(busy), .load(load), .rdata(bus_rdata)
  );

  txu_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy), .tick(tick)
  );

  txu_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .load(load), .wdata(bus_wdata), .tick(tick),
    .accept(accept), .busy(busy), .tx_line(tx_line)
  );

  p_nonmatch_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != TX_ADDR && !busy) |=> tx_line);
endmodule

// File: tb/mmio_serial_tx_tb.sv
module mmio_serial_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int B = 4;
  localparam int FRAME = 10 * B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic tx_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_serial_tx #(.BIT_CLKS(B)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tx_line(tx_line)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected line level t cycles after the accepting edge
  function automatic bit exp_line(input logic [7:0] d, input int t);
    int bitn = t / B;
    if (bitn == 0) return 1'b0;
    if (bitn <= 8) return d[bitn-1];
    return 1'b1;
  endfunction

  function automatic string req_of(input int t);
    int bitn = t / B;
    if (bitn == 0) return "R2";
    if (bitn <= 8) return "R3";
    return "R4";
  endfunction

  task automatic status_read(input int exp);
    bus_addr = 16'hFFFE; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata == 8'(exp), "R5", bus_rdata, exp);
    @(negedge clk);
    chk(bus_rdata == 8'h00, "R9", bus_rdata, 0);
  endtask

  // send a byte; optionally poll and issue an ignored write mid-frame
  task automatic send(input logic [7:0] d, input int poll_t, input int ign_t,
                      input logic [7:0] ign_d);
    bus_addr = 16'hFFFF; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int t = 0; t < FRAME; t++) begin
      chk(tx_line == exp_line(d, t), req_of(t), tx_line, exp_line(d, t));
      if (t == poll_t + 1) begin
        bus_rd = 1'b0;
        chk(bus_rdata == 8'h01, "R5", bus_rdata, 1);
      end
      if (t == ign_t + 1) bus_wr = 1'b0;
      if (t == poll_t) begin
        bus_addr = 16'hFFFE; bus_rd = 1'b1;
      end else if (t == ign_t) begin
        bus_addr = 16'hFFFF; bus_wdata = ign_d; bus_wr = 1'b1;
      end
      @(negedge clk);
    end
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk(tx_line == 1'b1, "R6", tx_line, 1);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    @(negedge clk);
    chk(tx_line == 1'b1, "R1", tx_line, 1);
    chk(bus_rdata == 8'h00, "R1", bus_rdata, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_line == 1'b1, "R1", tx_line, 1);
    status_read(0);

    // R8: writes to other addresses start nothing
    for (int k = 0; k < 4; k++) begin
      bus_addr = (k == 0) ? 16'hFFFE : 16'($urandom_range(0, 16'hFFFD));
      bus_wdata = 8'h00; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      for (int c = 0; c < 2 * B; c++) begin
        chk(tx_line == 1'b1, "R8", tx_line, 1);
        @(negedge clk);
      end
      status_read(0);
    end

    // R9: read of a non-status address returns 0
    bus_addr = 16'hFFFF; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata == 8'h00, "R9", bus_rdata, 0);

    // directed corner bytes
    send(8'h00, 0, -5, 8'h00);
    send(8'hFF, FRAME - 3, 2, 8'h00);
    send(8'h01, 5, FRAME - 3, 8'hFE);
    // R6: back-to-back right after the frame ends
    send(8'h80, 3, 7, 8'h7F);
    send(8'hA5, 10, 1, 8'h5A);
    status_read(0);

    // random frames
    for (int n = 0; n < 30; n++) begin
      logic [7:0] d;
      int pt, it;
      d  = 8'($urandom);
      pt = $urandom_range(0, FRAME - 3);
      it = $urandom_range(0, FRAME - 3);
      if (it == pt || it == pt + 1 || it + 1 == pt) it = -5;
      send(d, pt, it, ~d); // R7: ignored write carries a different byte
      status_read(0);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      chk(tx_line == 1'b1, "R4", tx_line, 1);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule